// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between on-chip logic and an external asynchronous static RAM of 32768 bytes. The RAM has a 15-bit address, an 8-bit bidirectional data bus and three active-low strobes: chip select, output enable and write enable. Each request carries an address, a write flag and write data. The controller turns it into one correctly timed read or write cycle on the RAM pins. All timing windows are whole system-clock cycles, and each is set by a parameter rounded up from the RAM's nanosecond minimums.

A request is accepted when `req_valid_i` and `req_ready_o` are both high. The controller then registers the address and the write data and holds them for the whole cycle. Ready stays low until the cycle is over. A read keeps chip select and output enable low for `TRC` cycles and captures the bus on the last of them. One cycle later, a one-cycle `rd_valid_o` pulse is issued together with the captured byte.

A write first drops chip select with output enable high for `TOHZ` cycles. This gives the RAM time to release the bus. Write enable then falls, and the controller drives the data for `max(TWP,TDW)` cycles. A final cycle raises write enable while the data is still held. The address only ever changes while write enable is high, and the controller never drives the bus while output enable is low.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted, and in every cycle with no request in flight, chip select, output enable and write enable are high (inactive), the data drive enable is low, ready is high and `rd_valid_o` is low.
- R2: A read accepted at clock edge E holds chip select and output enable low and write enable high for exactly the `TRC` cycles that follow E, with the data drive enable low.
- R3: The read byte is the bus value in the last of those `TRC` cycles. It appears on `rd_data_o` together with a `rd_valid_o` pulse that lasts exactly one cycle, in cycle `TRC+1` after acceptance.
- R4: A read ends with one cycle in which all three strobes are high, and ready returns in the cycle after it.
- R5: A write accepted at edge E first spends `TOHZ` cycles with chip select low, output enable high, write enable high and the data drive enable low.
- R6: Write enable then stays low for `max(TWP,TDW)` consecutive cycles. During those cycles chip select is low, output enable is high, and the drive enable is high with the accepted write data on `ram_dq_o`.
- R7: After the pulse comes one cycle with write enable high, chip select still low and data still driven. Then all strobes go inactive and ready returns.
- R8: `ram_addr_o` equals the address accepted with the current request in every cycle in which chip select is low, and it never changes while write enable is low. Later changes on the request inputs have no effect.
- R9: Ready is low from the edge that accepts a request until the cycle is over, and a request held valid during that time is not taken before ready returns.
- R10: The data drive enable is never high while output enable is low, and the controller only drives after output enable has been high for more than `TOHZ` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| rd_valid_o | output | 1 | One-cycle pulse, read data valid |
| rd_data_o | output | DATA_W | Captured read data |
| ram_addr_o | output | ADDR_W | RAM address pins |
| ram_ce_no | output | 1 | RAM chip select, active low |
| ram_oe_no | output | 1 | RAM output enable, active low |
| ram_we_no | output | 1 | RAM write enable, active low |
| ram_dq_o | output | DATA_W | Data driven toward the RAM |
| ram_dq_oe_o | output | 1 | Tristate enable for `ram_dq_o` |
| ram_dq_i | input | DATA_W | Data seen on the RAM bus |

## Verification
The assertions assume parameters that meet the sequencer's minimums (`TRC` of at least 2, `TOHZ` of at least 1). They also assume the external RAM drives the bus only while it is selected with output enable low and write enable high. The behavioural RAM in the bench obeys exactly that window and returns a computed fill pattern for unwritten words. The bench keeps `req_valid_i` high through busy cycles and scrambles the request fields right after acceptance, so any early acceptance or unregistered path shows up at the pins. A scoreboard follows every write and compares each read-back byte against it.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_SAMPLE,
    ST_RECOVER,
    ST_WR_TURN,
    ST_WR_PULSE,
    ST_WR_END
  } ctrl_state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } pin_ctl_t;

  // Pin levels are a pure function of the registered state.
  function automatic pin_ctl_t pins_for(ctrl_state_e st);
    pin_ctl_t p;
    p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
    case (st)
      ST_RD_ACCESS, ST_RD_SAMPLE: begin
        p.ce_n = 1'b0;
        p.oe_n = 1'b0;
      end
      ST_WR_TURN: p.ce_n = 1'b0;
      ST_WR_PULSE: begin
        p.ce_n  = 1'b0;
        p.we_n  = 1'b0;
        p.dq_oe = 1'b1;
      end
      ST_WR_END: begin
        p.ce_n  = 1'b0;
        p.dq_oe = 1'b1;
      end
      default: p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int TRC    = 4,
  parameter int TOHZ   = 2,
  parameter int WP_CYC = 3,
  parameter int CNT_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic             cnt_zero_i,
  output ctrl_state_e      state_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_val_o
);

  localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(TRC - 2);
  localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TOHZ - 1);
  localparam logic [CNT_W-1:0] WP_LOAD   = CNT_W'(WP_CYC - 1);

  ctrl_state_e state_q, state_d;

  assign accept_o  = req_valid_i && (state_q == ST_IDLE);
  assign capture_o = (state_q == ST_RD_SAMPLE);
  assign state_o   = state_q;

  always_comb begin
    state_d    = state_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          cnt_load_o = 1'b1;
          if (req_we_i) begin
            state_d   = ST_WR_TURN;
            cnt_val_o = TURN_LOAD;
          end else begin
            state_d   = ST_RD_ACCESS;
            cnt_val_o = RD_LOAD;
          end
        end
      end
      ST_RD_ACCESS: if (cnt_zero_i) state_d = ST_RD_SAMPLE;
      ST_RD_SAMPLE: state_d = ST_RECOVER;
      ST_RECOVER:   state_d = ST_IDLE;
      ST_WR_TURN: begin
        if (cnt_zero_i) begin
          state_d    = ST_WR_PULSE;
          cnt_load_o = 1'b1;
          cnt_val_o  = WP_LOAD;
        end
      end
      ST_WR_PULSE: if (cnt_zero_i) state_d = ST_WR_END;
      ST_WR_END:   state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

endmodule

// File: rtl/sram_dpath.sv
module sram_dpath #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_valid_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rd_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q    <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= capture_i;
      if (capture_i) rdata_q <= dq_i;
    end
  end

  assign addr_o     = addr_q;
  assign wdata_o    = wdata_q;
  assign rdata_o    = rdata_q;
  assign rd_valid_o = rd_valid_q;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int TRC    = 4,
  parameter int TWP    = 3,
  parameter int TDW    = 2,
  parameter int TOHZ   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_ce_no,
  output logic              ram_oe_no,
  output logic              ram_we_no,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe_o,
  input  logic [DATA_W-1:0] ram_dq_i
);

  // Pulse must cover both the minimum width and the data setup window.
  localparam int WP_CYC   = (TWP > TDW) ? TWP : TDW;
  localparam int MAX_LOAD = (TRC > WP_CYC) ? ((TRC > TOHZ) ? TRC : TOHZ)
                                           : ((WP_CYC > TOHZ) ? WP_CYC : TOHZ);
  localparam int CNT_W    = (MAX_LOAD < 2) ? 1 : $clog2(MAX_LOAD + 1);

  ctrl_state_e      state;
  pin_ctl_t         pins;
  logic             accept;
  logic             capture;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_zero;

  sram_seq #(
    .TRC    (TRC),
    .TOHZ   (TOHZ),
    .WP_CYC (WP_CYC),
    .CNT_W  (CNT_W)
  ) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .cnt_zero_i  (cnt_zero),
    .state_o     (state),
    .accept_o    (accept),
    .capture_o   (capture),
    .cnt_load_o  (cnt_load),
    .cnt_val_o   (cnt_val)
  );

  sram_wait_cnt #(
    .CNT_W (CNT_W)
  ) i_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .zero_o     (cnt_zero)
  );

  sram_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_dpath (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .addr_i     (req_addr_i),
    .wdata_i    (req_wdata_i),
    .capture_i  (capture),
    .dq_i       (ram_dq_i),
    .addr_o     (ram_addr_o),
    .wdata_o    (ram_dq_o),
    .rdata_o    (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );

  assign pins        = pins_for(state);
  assign ram_ce_no   = pins.ce_n;
  assign ram_oe_no   = pins.oe_n;
  assign ram_we_no   = pins.we_n;
  assign ram_dq_oe_o = pins.dq_oe;
  assign req_ready_o = (state == ST_IDLE);

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 15,
  parameter int TWP    = 3,
  parameter int TDW    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rd_valid_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              ram_ce_no,
  input logic              ram_oe_no,
  input logic              ram_we_no,
  input logic              ram_dq_oe_o
);

  localparam int WP_CYC = (TWP > TDW) ? TWP : TDW;

  logic [7:0] wlow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           wlow_q <= '0;
    else if (ram_we_no)    wlow_q <= '0;
    else if (wlow_q != '1) wlow_q <= wlow_q + 1'b1;
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (ram_ce_no && ram_we_no && !ram_dq_oe_o));

  p_rdv_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  p_rdv_deselect_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (ram_ce_no && ram_oe_no));

  p_we_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_no |-> (ram_dq_oe_o && !ram_ce_no));

  p_pulse_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_we_no) |-> (int'(wlow_q) >= WP_CYC));

  p_addr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_no |=> (ram_we_no || $stable(ram_addr_o)));

  p_busy_after_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_no_drive_oe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_dq_oe_o |-> ram_oe_no);

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .TWP    (TWP),
  .TDW    (TDW)
) i_sram_ctrl_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rd_valid_o  (rd_valid_o),
  .ram_addr_o  (ram_addr_o),
  .ram_ce_no   (ram_ce_no),
  .ram_oe_no   (ram_oe_no),
  .ram_we_no   (ram_we_no),
  .ram_dq_oe_o (ram_dq_oe_o)
);

// File: tb/test_sram_ctrl.sv
module test_sram_ctrl;

  localparam int CLK_PERIOD = 20;
  localparam int AW   = 15;
  localparam int DW   = 8;
  localparam int TRC  = 4;
  localparam int TWP  = 3;
  localparam int TDW  = 2;
  localparam int TOHZ = 2;
  localparam int WP   = (TWP > TDW) ? TWP : TDW;

  // {ready, ce_n, oe_n, we_n, dq_oe, rd_valid}
  localparam logic [5:0] V_IDLE = 6'b111100;
  localparam logic [5:0] V_RD   = 6'b000100;
  localparam logic [5:0] V_RREC = 6'b011101;
  localparam logic [5:0] V_TURN = 6'b001100;
  localparam logic [5:0] V_WP   = 6'b001010;
  localparam logic [5:0] V_WEND = 6'b001110;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready_o, rd_valid_o, ram_ce_no, ram_oe_no, ram_we_no, ram_dq_oe_o;
  logic [DW-1:0] rd_data_o, ram_dq_o;
  logic [AW-1:0] ram_addr_o;
  logic [DW-1:0] ram_dq_i;

  int n_chk = 0;
  int n_bad = 0;
  bit mon_en = 0;
  bit rdy_seen = 0;

  logic [5:0]    exp_q[$];
  string         tag_q[$];
  logic [DW-1:0] rd_exp_q[$];
  logic [DW-1:0] ram_mem[int];
  logic [DW-1:0] sb[int];

  logic [AW-1:0] cur_addr = '0;
  logic [DW-1:0] cur_wdata = '0;

  // RAM model state
  int            oe_hi = 1000;
  int            wlow = 0;
  logic          prev_we_n = 1'b1;
  logic [AW-1:0] wr_addr_hold = '0;
  logic [DW-1:0] wr_dat = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sram_ctrl #(
    .ADDR_W (AW), .DATA_W (DW), .TRC (TRC), .TWP (TWP), .TDW (TDW), .TOHZ (TOHZ)
  ) i_sram_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready_o),
    .req_we_i    (req_we),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o),
    .ram_addr_o  (ram_addr_o),
    .ram_ce_no   (ram_ce_no),
    .ram_oe_no   (ram_oe_no),
    .ram_we_no   (ram_we_no),
    .ram_dq_o    (ram_dq_o),
    .ram_dq_oe_o (ram_dq_oe_o),
    .ram_dq_i    (ram_dq_i)
  );

  function automatic logic [DW-1:0] fill(int a);
    return DW'((a ^ (a >> 7) ^ 165) & 255);
  endfunction

  function automatic logic [DW-1:0] mem_rd(int a);
    if (ram_mem.exists(a)) return ram_mem[a];
    return fill(a);
  endfunction

  // RAM drives only while selected, output enabled and not writing.
  always @* begin
    if (!ram_ce_no && !ram_oe_no && ram_we_no) ram_dq_i = mem_rd(int'(ram_addr_o));
    else                                       ram_dq_i = '0;
  end

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // Per-cycle comparison and RAM protocol checks, away from the active edge.
  always @(negedge clk) begin
    logic [5:0]    e;
    logic [5:0]    act;
    string         t;
    logic [DW-1:0] rexp;
    if (rst_ni && mon_en) begin
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
      end else begin
        e = V_IDLE;
        t = "R1";
      end
      act = {req_ready_o, ram_ce_no, ram_oe_no, ram_we_no, ram_dq_oe_o, rd_valid_o};
      chk(act[5] == e[5], "R9", "ready", act[5], e[5]);
      chk(act[4:1] == e[4:1], t, "strobes ce/oe/we/drive", act[4:1], e[4:1]);
      chk(act[0] == e[0], "R3", "rd_valid", act[0], e[0]);
      if (rd_valid_o) begin
        rexp = (rd_exp_q.size() > 0) ? rd_exp_q.pop_front() : 'x;
        chk(rd_data_o === rexp, "R3", "read data", rd_data_o, rexp);
      end
      if (!ram_ce_no) chk(ram_addr_o == cur_addr, "R8", "address", ram_addr_o, cur_addr);

      if (ram_oe_no) oe_hi = (oe_hi < 1000) ? oe_hi + 1 : oe_hi;
      else           oe_hi = 0;
      if (ram_dq_oe_o) begin
        chk(ram_dq_o == cur_wdata, "R6", "driven write data", ram_dq_o, cur_wdata);
        chk(oe_hi > TOHZ, "R10", "drive before bus release", oe_hi, TOHZ + 1);
      end

      if (!ram_we_no) begin
        if (!prev_we_n) chk(ram_addr_o == wr_addr_hold, "R8", "address moved under write enable",
                            ram_addr_o, wr_addr_hold);
        wr_addr_hold = ram_addr_o;
        wr_dat = ram_dq_o;
        wlow++;
      end else if (!prev_we_n) begin
        chk(wlow >= TWP, "R6", "write pulse cycles", wlow, TWP);
        ram_mem[int'(wr_addr_hold)] = wr_dat;
        wlow = 0;
      end
      prev_we_n = ram_we_no;
    end
    rdy_seen = req_ready_o;
  end

  // Offer a request and hold it until the controller takes it.
  task automatic issue(bit we, int addr, logic [DW-1:0] d);
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = AW'(addr);
    req_wdata = d;
    do @(posedge clk); while (!rdy_seen);
    cur_addr  = AW'(addr);
    cur_wdata = d;
    if (we) begin
      sb[addr] = d;
      for (int i = 0; i < TOHZ; i++) begin exp_q.push_back(V_TURN); tag_q.push_back("R5"); end
      for (int i = 0; i < WP; i++)   begin exp_q.push_back(V_WP);   tag_q.push_back("R6"); end
      exp_q.push_back(V_WEND); tag_q.push_back("R7");
    end else begin
      rd_exp_q.push_back(sb.exists(addr) ? sb[addr] : fill(addr));
      for (int i = 0; i < TRC; i++) begin exp_q.push_back(V_RD); tag_q.push_back("R2"); end
      exp_q.push_back(V_RREC); tag_q.push_back("R4");
    end
    #1;
    // Scramble request fields: they must not reach the pins (R8).
    req_valid = 1'b0;
    req_we    = ~we;
    req_addr  = ~AW'(addr);
    req_wdata = ~d;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk({req_ready_o, ram_ce_no, ram_oe_no, ram_we_no, ram_dq_oe_o, rd_valid_o} == V_IDLE,
          "R1", "reset pins",
          {req_ready_o, ram_ce_no, ram_oe_no, ram_we_no, ram_dq_oe_o, rd_valid_o}, V_IDLE);
    end
    rst_ni = 1'b1;
    mon_en = 1'b1;
    @(posedge clk);
    #1;

    // Boundary addresses and extreme data
    issue(1, 0, 8'h00);
    issue(1, 32767, 8'hFF);
    issue(1, 16'h1234, 8'h5A);
    issue(0, 0, 8'h00);
    issue(0, 32767, 8'h00);
    issue(0, 16'h1234, 8'h00);
    // Unwritten word returns the model's fill pattern
    issue(0, 777, 8'h00);
    // Back-to-back writes to one word, then read-after-write
    issue(1, 100, 8'h55);
    issue(1, 100, 8'hAA);
    issue(0, 100, 8'h00);
    // Back-to-back reads
    issue(0, 32767, 8'h00);
    issue(0, 0, 8'h00);
    // Mixed traffic
    for (int i = 0; i < 60; i++) begin
      int a;
      a = (i * 7919 + 13) & 32767;
      issue(1, a, 8'((i * 37) ^ 8'hC3));
      if (i % 3 == 0) issue(0, a, 8'h00);
      if (i % 5 == 4) issue(0, (a + 1) & 32767, 8'h00);
    end
    for (int i = 0; i < 60; i += 7) issue(0, (i * 7919 + 13) & 32767, 8'h00);

    repeat (TRC + TOHZ + WP + 6) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R9", "pending expectations", exp_q.size(), 0);
    chk(rd_exp_q.size() == 0, "R3", "missing read pulses", rd_exp_q.size(), 0);
    finish_run();
  end

endmodule